// File: doc/BRIEF.md
# Double-Buffered Sample Capture with Preprocessing

This block takes a stream of 12-bit two's-complement converter samples, each marked by a strobe. It writes them into one of two internal buffers while the other buffer waits, full, for a demodulator to read it. Each sample is sign-extended to 18 bits on entry. An optional filter replaces isolated spikes with the mean of their two neighbours. Full-scale input codes can be flagged per buffer. Several waveform periods can be summed in place and scaled back down by a power of two before a buffer is handed over.

Capture starts on the first strobed sample that comes with the period-start pulse. After that, samples are taken as one continuous stream. A period is `buf_len` samples long. A buffer is complete after 2^n periods, where n is the programmed averaging exponent. The reader sees `buf_rdy`, reads any word through the combinational read port, and then returns the buffer with a one-cycle release pulse. If both buffers are full when more data arrives, capture stops and samples are dropped. It resumes on the next period-start pulse once a buffer has been freed.

Top module: `acq_pingpong`

## Requirements
- R1: After a synchronous active-low reset, `buf_rdy` and `overrun` are 0.
- R2: With averaging exponent 0 and both filters off, buffer word i equals sample i of that buffer, where the 12-bit code is read as two's complement and sign-extended to 18 bits.
- R3: Completed buffers are presented alternately in bank 0, 1, 0, … starting from bank 0 after reset, as shown on `rd_bank`. A release pulse while `buf_rdy` is 1 drops `buf_rdy` when the other bank is not yet full. Capture carries on across a buffer change without losing a sample.
- R4: Strobed samples before the first one that comes with `period_start` are ignored. Once capture has started, further `period_start` pulses have no effect.
- R5: With `ovf_en` at 1, `rd_ovf` is 1 for a buffer that received any raw code 0x7FF or 0x800, judged before filtering. It is 0 otherwise, and always 0 with `ovf_en` at 0. The flag is cleared when the buffer is released.
- R6: With `spike_en` at 1, a sample whose sign-extended value differs from both its previous and its next stream neighbour by strictly more than `spike_thr` is replaced by floor((previous + next) / 2). Neighbours are taken in stream order, across period and buffer boundaries. The first sample after capture starts is never replaced.
- R7: With averaging exponent n, each word is the sum of the corresponding sample over 2^n consecutive periods, arithmetically shifted right by n (rounding toward minus infinity). Values of `avg_log2` above 6 act as 6.
- R8: When a buffer completes while the other is still unreleased, `overrun` becomes 1 and stays 1 until reset. The sample that arrived in that cycle, and every later sample, is dropped. The older buffer is presented first and the newer one after the first release. Capture restarts only on a `period_start` sample once a bank is free.
- R9: `buf_rdy` rises on the clock edge that accepts the first sample after the last sample of a buffer, and not before. `rd_data` follows `rd_addr` with no clock delay.
- R10: Any `buf_len` from 1 up to the parameter `MAX_LEN` (64 by default) gives a full buffer of that many words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | 12 | Raw two's-complement sample |
| period_start | input | 1 | Marks the first sample of a waveform period; starts capture |
| buf_len | input | 7 | Samples per period (1 to MAX_LEN) |
| avg_log2 | input | 3 | Averaging exponent n, 2^n periods per buffer |
| ovf_en | input | 1 | Enables full-scale flagging |
| spike_en | input | 1 | Enables spike replacement |
| spike_thr | input | 18 | Spike threshold, unsigned |
| rd_release | input | 1 | Returns the presented buffer |
| rd_addr | input | 6 | Word index in the presented buffer |
| buf_rdy | output | 1 | A full buffer is presented |
| rd_bank | output | 1 | Bank number of the presented buffer |
| rd_data | output | 18 | Word at `rd_addr`, signed |
| rd_ovf | output | 1 | Full-scale flag of the presented buffer |
| overrun | output | 1 | Sticky: samples were dropped for lack of a free bank |

## Verification
The spike filter holds each sample until its successor arrives. For that reason `buf_rdy` is due one clock after the strobe of the sample that follows a buffer's last sample. The bench therefore checks `buf_rdy` on the falling edge after every strobe, expecting 1 only at those stream positions. `rd_data`, `rd_bank` and `rd_ovf` are combinational from state, so each word is compared a short delay after `rd_addr` changes, between clock edges. `overrun` is checked on the falling edge after the strobe that completed the second buffer, and again after the dropped samples. Expected words come from a bench model of sign extension, neighbour filtering and period summing over the recorded raw stream.

// File: rtl/acq_pkg.sv
// Shared widths and sample arithmetic for the capture block.
// Assumes a two's-complement converter code narrower than the stored sample.
package acq_pkg;
    localparam int ADC_W  = 12;
    localparam int DATA_W = 18;

    // Widen a raw converter code to the stored sample width.
    function automatic logic signed [DATA_W-1:0] sext_code(input logic [ADC_W-1:0] c);
        return {{(DATA_W-ADC_W){c[ADC_W-1]}}, c};
    endfunction

    // True when the raw code sits at either end of the converter range.
    function automatic logic is_full_scale(input logic [ADC_W-1:0] c);
        return (c == {1'b0, {(ADC_W-1){1'b1}}}) || (c == {1'b1, {(ADC_W-1){1'b0}}});
    endfunction

    // Magnitude of a difference, one bit wider than the operands.
    function automatic logic [DATA_W:0] abs_diff(input logic signed [DATA_W-1:0] a,
                                                 input logic signed [DATA_W-1:0] b);
        logic signed [DATA_W:0] d;
        d = (DATA_W+1)'(a) - (DATA_W+1)'(b);
        return d[DATA_W] ? -d : d;
    endfunction

    // Floor of the mean of two samples.
    function automatic logic signed [DATA_W-1:0] mean2(input logic signed [DATA_W-1:0] a,
                                                       input logic signed [DATA_W-1:0] b);
        logic signed [DATA_W:0] s;
        s = (DATA_W+1)'(a) + (DATA_W+1)'(b);
        return DATA_W'(s >>> 1);
    endfunction
endpackage

// File: rtl/acq_front.sv
// Input stage: sign extension, full-scale detection and the spike filter.
// A sample leaves this stage when the next sample arrives, because the filter
// needs both neighbours. Assumes in_vld is only asserted for accepted samples.
module acq_front
    import acq_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_vld,
    input  logic [ADC_W-1:0]         in_code,
    input  logic                     flush,
    input  logic                     spike_en,
    input  logic [DATA_W-1:0]        spike_thr,
    output logic                     out_vld,
    output logic signed [DATA_W-1:0] out_val,
    output logic                     out_fs
);
    logic                     prv_v, cur_v, cur_fs;
    logic signed [DATA_W-1:0] prv, cur;
    logic signed [DATA_W-1:0] inc;
    logic                     is_spike;

    // Filter decision on the held sample using the incoming one as its successor.
    always_comb begin
        inc      = sext_code(in_code);
        is_spike = spike_en && prv_v
                   && (abs_diff(cur, prv) > {1'b0, spike_thr})
                   && (abs_diff(cur, inc) > {1'b0, spike_thr});
        out_vld  = in_vld && cur_v;
        out_val  = is_spike ? mean2(prv, inc) : cur;
        out_fs   = cur_fs;
    end

    // Two-deep history of accepted samples; flush forgets both.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            prv_v  <= 1'b0;
            cur_v  <= 1'b0;
            cur_fs <= 1'b0;
            prv    <= '0;
            cur    <= '0;
        end else if (in_vld) begin
            prv    <= cur;
            prv_v  <= cur_v;
            cur    <= inc;
            cur_v  <= 1'b1;
            cur_fs <= is_full_scale(in_code);
        end
    end

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !out_vld); // R8
endmodule

// File: rtl/acq_bank.sv
// Two-bank accumulation store. A write either overwrites a word (first period)
// or adds to it (later periods). The read port shifts the sum down by the
// averaging exponent. Assumes DEPTH is a power of two.
module acq_bank #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 18,
    parameter int ACC_W  = 24,
    parameter int SHW    = 3,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     wr_en,
    input  logic                     wr_bank,
    input  logic [AW-1:0]            wr_addr,
    input  logic                     wr_first,
    input  logic signed [DATA_W-1:0] wr_val,
    input  logic                     rd_bank,
    input  logic [AW-1:0]            rd_addr,
    input  logic [SHW-1:0]           shift,
    output logic signed [DATA_W-1:0] rd_data
);
    logic signed [ACC_W-1:0] mem [2*DEPTH];
    logic signed [ACC_W-1:0] acc_rd;

    // Read-modify-write of one accumulator word per accepted sample.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[{wr_bank, wr_addr}] <= wr_first ? ACC_W'(wr_val)
                                                : mem[{wr_bank, wr_addr}] + ACC_W'(wr_val);
    end

    // Combinational read of the presented bank, scaled by the period count.
    always_comb begin
        acc_rd  = mem[{rd_bank, rd_addr}];
        rd_data = DATA_W'(acc_rd >>> shift);
    end
endmodule

// File: rtl/acq_pingpong.sv
// Double-buffered capture control. Arms on period_start, counts samples and
// periods, swaps banks on completion, flags full-scale codes and overruns.
// Assumes buf_len, avg_log2 and the enables stay stable while capturing.
module acq_pingpong
    import acq_pkg::*;
#(
    parameter int  MAX_LEN      = 64,
    parameter int  MAX_AVG_LOG2 = 6,
    localparam int AW    = $clog2(MAX_LEN),
    localparam int LEN_W = $clog2(MAX_LEN + 1),
    localparam int SHW   = $clog2(MAX_AVG_LOG2 + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  smp_valid,
    input  logic [ADC_W-1:0]      smp_code,
    input  logic                  period_start,
    input  logic [LEN_W-1:0]      buf_len,
    input  logic [SHW-1:0]        avg_log2,
    input  logic                  ovf_en,
    input  logic                  spike_en,
    input  logic [DATA_W-1:0]     spike_thr,
    input  logic                  rd_release,
    input  logic [AW-1:0]         rd_addr,
    output logic                  buf_rdy,
    output logic                  rd_bank,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  rd_ovf,
    output logic                  overrun
);
    localparam int ACC_W = DATA_W + MAX_AVG_LOG2;
    localparam int PER_W = MAX_AVG_LOG2;

    logic [1:0]       full_q, ovf_q;
    logic             fill_q, armed_q, ovr_q;
    logic [AW-1:0]    idx_q;
    logic [PER_W-1:0] per_q;

    logic [SHW-1:0]   n_eff;
    logic [PER_W-1:0] per_lim;
    logic             rd_side, rel, other_busy, arm_now, drop, fe_in;
    logic             wr, wr_fs, last_smp, complete, flush;
    logic signed [DATA_W-1:0] wr_val, rd_val;

    // Effective averaging exponent and the matching last-period index.
    always_comb begin
        n_eff   = (avg_log2 > SHW'(MAX_AVG_LOG2)) ? SHW'(MAX_AVG_LOG2) : avg_log2;
        per_lim = PER_W'((32'd1 << n_eff) - 32'd1);
    end

    // Bank handshake, arming and completion decode.
    always_comb begin
        rd_side    = ~fill_q;
        rel        = rd_release & full_q[rd_side];
        other_busy = full_q[rd_side] & ~rel;
        arm_now    = ~armed_q & smp_valid & period_start & ~full_q[fill_q];
        drop       = ~armed_q & smp_valid & full_q[fill_q];
        fe_in      = smp_valid & (armed_q | arm_now);
        last_smp   = LEN_W'(idx_q) == (buf_len - 1'b1);
        complete   = wr & last_smp & (per_q == per_lim);
        flush      = complete & other_busy;
    end

    acq_front u_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_vld    (fe_in),
        .in_code   (smp_code),
        .flush     (flush),
        .spike_en  (spike_en),
        .spike_thr (spike_thr),
        .out_vld   (wr),
        .out_val   (wr_val),
        .out_fs    (wr_fs)
    );

    acq_bank #(
        .DEPTH  (MAX_LEN),
        .DATA_W (DATA_W),
        .ACC_W  (ACC_W),
        .SHW    (SHW)
    ) u_bank (
        .clk      (clk),
        .wr_en    (wr),
        .wr_bank  (fill_q),
        .wr_addr  (idx_q),
        .wr_first (per_q == '0),
        .wr_val   (wr_val),
        .rd_bank  (rd_side),
        .rd_addr  (rd_addr),
        .shift    (n_eff),
        .rd_data  (rd_val)
    );

    // Capture sequencing: arm, index/period counting, swap, flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 2'b00;
            ovf_q   <= 2'b00;
            fill_q  <= 1'b0;
            armed_q <= 1'b0;
            ovr_q   <= 1'b0;
            idx_q   <= '0;
            per_q   <= '0;
        end else begin
            if (rel) begin
                full_q[rd_side] <= 1'b0;
                ovf_q[rd_side]  <= 1'b0;
                if (!armed_q && full_q[fill_q])
                    fill_q <= ~fill_q;
            end
            if (arm_now) begin
                armed_q <= 1'b1;
                idx_q   <= '0;
                per_q   <= '0;
            end
            if (wr) begin
                ovf_q[fill_q] <= ovf_q[fill_q] | (ovf_en & wr_fs);
                if (last_smp) begin
                    idx_q <= '0;
                    per_q <= (per_q == per_lim) ? '0 : per_q + 1'b1;
                end else begin
                    idx_q <= idx_q + 1'b1;
                end
                if (complete) begin
                    full_q[fill_q] <= 1'b1;
                    if (other_busy) begin
                        armed_q <= 1'b0;
                        ovr_q   <= 1'b1;
                    end else begin
                        fill_q <= ~fill_q;
                    end
                end
            end
            if (drop)
                ovr_q <= 1'b1;
        end
    end

    // Presented-buffer view.
    always_comb begin
        buf_rdy = full_q[rd_side];
        rd_bank = rd_side;
        rd_data = rd_val;
        rd_ovf  = ovf_q[rd_side];
        overrun = ovr_q;
    end

    AST_NO_FILL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> !full_q[fill_q]); // R3
    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> (LEN_W'(idx_q) < buf_len)); // R10
    AST_OVERRUN_BOTH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> (full_q == 2'b11)); // R8
    AST_NO_WRITE_BOTH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q == 2'b11) |-> !wr); // R8
    AST_OVF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rdy && rd_ovf && !rd_release) |=> rd_ovf); // R5
endmodule

// File: tb/acq_pingpong_tb.sv
module acq_pingpong_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [11:0] smp_code = '0;
    logic        period_start = 1'b0;
    logic [6:0]  buf_len = 7'd8;
    logic [2:0]  avg_log2 = '0;
    logic        ovf_en = 1'b0;
    logic        spike_en = 1'b0;
    logic [17:0] spike_thr = '0;
    logic        rd_release = 1'b0;
    logic [5:0]  rd_addr = '0;
    logic        buf_rdy, rd_bank, rd_ovf, overrun;
    logic [17:0] rd_data;

    acq_pingpong u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_code(smp_code),
        .period_start(period_start), .buf_len(buf_len), .avg_log2(avg_log2),
        .ovf_en(ovf_en), .spike_en(spike_en), .spike_thr(spike_thr),
        .rd_release(rd_release), .rd_addr(rd_addr), .buf_rdy(buf_rdy),
        .rd_bank(rd_bank), .rd_data(rd_data), .rd_ovf(rd_ovf), .overrun(overrun)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int L, P, NSH, THR;
    bit SPK, OVE, eb;
    int s [0:1023];
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sx(input int c);
        int v = c & 'hFFF;
        return (v >= 2048) ? v - 4096 : v;
    endfunction

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    function automatic int fval(input int k);
        int b = sx(s[k]);
        if (SPK && k >= 1) begin
            int a = sx(s[k-1]);
            int c = sx(s[k+1]);
            if (iabs(b - a) > THR && iabs(b - c) > THR) return (a + c) >>> 1;
        end
        return b;
    endfunction

    function automatic int expv(input int j, input int i);
        int sum = 0;
        for (int p = 0; p < P; p++) sum += fval(j*L*P + p*L + i);
        return sum >>> NSH;
    endfunction

    function automatic int expo(input int j);
        int v;
        if (!OVE) return 0;
        for (int k = j*L*P; k < (j+1)*L*P; k++) begin
            v = s[k] & 'hFFF;
            if (v == 'h7FF || v == 'h800) return 1;
        end
        return 0;
    endfunction

    task automatic fill_rand(input int n, input int span);
        for (int k = 0; k < n; k++) begin
            if (span == 0) s[k] = int'($urandom & 32'hFFF);
            else s[k] = (int'($urandom % (2*span+1)) - span) & 'hFFF;
        end
    endtask

    task automatic send(input int c, input bit ps);
        @(negedge clk);
        smp_valid = 1'b1; smp_code = 12'(c); period_start = ps;
        @(negedge clk);
        smp_valid = 1'b0; period_start = 1'b0;
    endtask

    task automatic release_buf();
        @(negedge clk);
        rd_release = 1'b1;
        @(negedge clk);
        rd_release = 1'b0;
    endtask

    task automatic check_buf(input int j, input bit bank, input string req);
        chk(rd_bank == bank, "R3 bank", int'(rd_bank), int'(bank));
        chk(rd_ovf == expo(j)[0], "R5 flag", int'(rd_ovf), expo(j));
        for (int i = 0; i < L; i++) begin
            int got;
            @(negedge clk);
            rd_addr = 6'(i);
            #2;
            got = $signed(rd_data);
            chk(got == expv(j, i), req, got, expv(j, i));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic setup(input int len, input int avgf, input bit ove, input bit spk, input int thr);
        L = len; NSH = (avgf > 6) ? 6 : avgf; P = 1 << NSH;
        OVE = ove; SPK = spk; THR = thr;
        buf_len = 7'(len); avg_log2 = 3'(avgf); ovf_en = ove; spike_en = spk;
        spike_thr = 18'(thr);
        do_reset();
        eb = 1'b0;
    endtask

    task automatic run_std(input int len, input int avgf, input bit ove, input bit spk,
                           input int thr, input int nbuf, input int prearm, input int ps2,
                           input string req);
        setup(len, avgf, ove, spk, thr);
        for (int q = 0; q < prearm; q++) send(int'($urandom), 1'b0);
        for (int k = 0; k <= nbuf*L*P; k++) begin
            send(s[k], (k == 0) || (k == ps2));
            if (k > 0 && (k % (L*P)) == 0) begin
                chk(buf_rdy == 1'b1, "R9 ready due", int'(buf_rdy), 1);
                check_buf(k/(L*P) - 1, eb, req);
                release_buf();
                chk(buf_rdy == 1'b0, "R3 release", int'(buf_rdy), 0);
                eb = ~eb;
            end else begin
                chk(buf_rdy == 1'b0, "R9 early", int'(buf_rdy), 0);
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        do_reset();
        chk(buf_rdy == 1'b0, "R1 ready", int'(buf_rdy), 0);
        chk(overrun == 1'b0, "R1 overrun", int'(overrun), 0);

        // R2, R3, R4: plain capture, samples before arming ignored, extra period_start at k=5.
        fill_rand(33, 0);
        run_std(8, 0, 1'b0, 1'b0, 0, 4, 3, 5, "R2 R4 data");

        // R5: full-scale codes flagged per buffer with ovf_en on.
        fill_rand(25, 0);
        for (int k = 16; k < 25; k++)
            if ((s[k] & 'hFFF) == 'h7FF || (s[k] & 'hFFF) == 'h800) s[k] = 'h123;
        s[3] = 'h7FF; s[10] = 'h800;
        run_std(8, 0, 1'b1, 1'b0, 0, 3, 0, -1, "R5 data");

        // R5: ovf_en off leaves the flag clear.
        fill_rand(9, 0);
        s[2] = 'h7FF;
        run_std(8, 0, 1'b0, 1'b0, 0, 1, 0, -1, "R5 disabled");

        // R6: isolated, adjacent, boundary and exact-threshold spikes.
        fill_rand(49, 40);
        s[0] = 1500; s[5] = (-1500) & 'hFFF; s[15] = 1200;
        s[20] = 1000; s[21] = 1000;
        s[29] = 0; s[30] = 100; s[31] = 0;
        run_std(8, 1, 1'b0, 1'b1, 100, 3, 0, -1, "R6 data");

        // R7: exponent 7 acts as 6 (64 periods).
        fill_rand(513, 0);
        run_std(4, 7, 1'b0, 1'b0, 0, 2, 0, -1, "R7 data");

        // R10: largest buffer length with two-period averaging.
        fill_rand(257, 0);
        run_std(64, 1, 1'b0, 1'b0, 0, 2, 0, -1, "R10 data");

        // R8: overrun when the reader falls behind.
        fill_rand(17, 0);
        setup(8, 0, 1'b0, 1'b0, 0);
        for (int k = 0; k <= 16; k++) begin
            send(s[k], k == 0);
            if (k < 16) chk(overrun == 1'b0, "R8 no overrun yet", int'(overrun), 0);
        end
        chk(overrun == 1'b1, "R8 overrun set", int'(overrun), 1);
        chk(buf_rdy == 1'b1, "R8 ready", int'(buf_rdy), 1);
        check_buf(0, 1'b0, "R8 older first");
        for (int q = 0; q < 3; q++) send(int'($urandom), 1'b0);
        release_buf();
        send(int'($urandom), 1'b0);
        chk(buf_rdy == 1'b1, "R8 newer ready", int'(buf_rdy), 1);
        check_buf(1, 1'b1, "R8 newer data");
        release_buf();
        chk(buf_rdy == 1'b0, "R8 drained", int'(buf_rdy), 0);
        fill_rand(9, 0);
        for (int k = 0; k <= 8; k++) send(s[k], k == 0);
        chk(buf_rdy == 1'b1, "R8 resumed", int'(buf_rdy), 1);
        check_buf(0, 1'b0, "R8 resumed data");
        chk(overrun == 1'b1, "R8 sticky", int'(overrun), 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule